// File: doc/BRIEF.md
# SDRAM Bank Decode and Open-Row Tracker

This block sits between a system-side request port and an SDRAM command sequencer. Each request carries a byte address. The block decides which of up to four external memory banks the address falls in. Each bank has its own enable, base address and size. The block then cuts the in-bank offset into row, column and internal-bank fields, using the geometry chosen for that bank.

The block also keeps a small shared table of rows that are currently open, with at most four entries across all banks. For every request it reports, one cycle later, one of three outcomes:

- **hit**: the same row is already open in that internal bank.
- **miss**: a different row is open there, so it must be closed first.
- **empty**: nothing is open there.

When an empty outcome needs a table entry and all four are taken, the least recently used entry is displaced. The block reports that entry's bank pair so the sequencer can precharge it. The sequencer tells the block when it closes one internal bank. It also tells the block when it closes everything, which happens on a precharge-all or a refresh.

Top module: `sdram_page_tracker`

## Requirements
- R1: A bank matches when its enable bit is set and the request address equals its base once the offset bits below the bank size are masked. The size code k gives 4 MB << k: code 0 is 4 MB and code 6 is 256 MB, and code 7 acts as 256 MB. When several enabled banks match, the lowest bank index wins and is reported on rsp_pbank.
- R2: An address matching no enabled bank gives rsp_err high for that one response, with hit, miss, empty and evict all low. The open-row table is left unchanged.
- R3: Every request cycle produces exactly one response, with rsp_valid high in the following cycle. No response appears without a request.
- R4: The in-bank offset is shifted right by two to form a 32-bit word address. Counting up from bit 0 of that word address, the fields are: the column (C bits), then the internal bank (1 bit, or 2 bits in 4-bank mode), then the row (R bits). The geometry code sets R x C: 0:11x8, 1:11x9, 2:12x8, 3:12x9, 4:12x10, 5:13x9, 6:13x10, 7:13x11.
- R5: A decoded request is a hit when the table holds the same row for the same physical and internal bank. It is a miss when it holds a different row there, and the table then records the new row. It is empty when nothing is held there. Exactly one outcome is flagged.
- R6: An empty request with all four table entries in use displaces the least recently used entry. It raises rsp_evict and reports that entry's physical and internal bank. rsp_evict is never raised otherwise. Any hit, miss or empty request counts as a use.
- R7: A close notification for a physical and internal bank removes its entry. The next request there reports empty, with no eviction.
- R8: A precharge-all notification empties the whole table within one clock, so the next request to any bank reports empty.
- R9: After reset, rsp_valid is low and the table is empty.
- R10: In 2-bank mode, rsp_ibank[1] is always 0 and the row starts one bit lower than in 4-bank mode. The mode is selected per physical bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | NB | Per-bank enable |
| cfg_base | input | NB*AW | Per-bank base address, aligned to its size |
| cfg_size | input | NB*3 | Per-bank size code (4 MB << code) |
| cfg_geom | input | NB*3 | Per-bank row x column geometry code |
| cfg_quad | input | NB | Per-bank 4-internal-bank mode (0 = 2 banks) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Request byte address |
| close_valid | input | 1 | One internal bank was closed |
| close_pbank | input | PBW | Physical bank of the close |
| close_ibank | input | 2 | Internal bank of the close |
| prech_all | input | 1 | Every row was closed (precharge-all or refresh) |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | No bank matched |
| rsp_hit | output | 1 | Row already open |
| rsp_miss | output | 1 | Other row open in that bank |
| rsp_empty | output | 1 | No row open in that bank |
| rsp_pbank | output | PBW | Decoded physical bank |
| rsp_row | output | RW | Row field |
| rsp_col | output | CW | Column field |
| rsp_ibank | output | 2 | Internal bank field |
| rsp_evict | output | 1 | An entry was displaced |
| rsp_evict_pbank | output | PBW | Physical bank of the displaced entry |
| rsp_evict_ibank | output | 2 | Internal bank of the displaced entry |

## Verification
The hardest situation to reach is a displacement where the victim is not simply the oldest entry written. Reaching it needs all four entries held by distinct bank pairs, followed by a recency order that differs from the insertion order.

The stimulus first fills the table from four bank pairs spread over three physical banks. It then re-touches them through hits and misses before forcing new pairs in. A later pseudo-random phase keeps the row choice to three values per bank, so hits, misses and displacements keep recurring. Close and precharge-all events are mixed into that phase.

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker #(
  parameter int NB = 4,
  parameter int AW = 32,
  parameter int RW = 13,
  parameter int CW = 11,
  parameter int NS = 4,
  parameter int MINLOG = 22,
  localparam int PBW = $clog2(NB),
  localparam int SW = $clog2(NS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     cfg_en,
  input  logic [NB*AW-1:0]  cfg_base,
  input  logic [NB*3-1:0]   cfg_size,
  input  logic [NB*3-1:0]   cfg_geom,
  input  logic [NB-1:0]     cfg_quad,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic              close_valid,
  input  logic [PBW-1:0]    close_pbank,
  input  logic [1:0]        close_ibank,
  input  logic              prech_all,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_empty,
  output logic [PBW-1:0]    rsp_pbank,
  output logic [RW-1:0]     rsp_row,
  output logic [CW-1:0]     rsp_col,
  output logic [1:0]        rsp_ibank,
  output logic              rsp_evict,
  output logic [PBW-1:0]    rsp_evict_pbank,
  output logic [1:0]        rsp_evict_ibank
);

  function automatic logic [3:0] row_bits(input logic [2:0] g);
    case (g)
      3'd0, 3'd1:       return 4'd11;
      3'd2, 3'd3, 3'd4: return 4'd12;
      default:          return 4'd13;
    endcase
  endfunction

  function automatic logic [3:0] col_bits(input logic [2:0] g);
    case (g)
      3'd0, 3'd2:       return 4'd8;
      3'd1, 3'd3, 3'd5: return 4'd9;
      3'd4, 3'd6:       return 4'd10;
      default:          return 4'd11;
    endcase
  endfunction

  logic [NB-1:0] match;
  logic [AW-1:0] msk [NB];

  for (genvar b = 0; b < NB; b++) begin : g_cmp
    logic [2:0] sz;
    assign sz = (cfg_size[b*3 +: 3] == 3'd7) ? 3'd6 : cfg_size[b*3 +: 3];
    assign msk[b] = ~((AW'(1) << (MINLOG + int'(sz))) - AW'(1));
    assign match[b] = cfg_en[b] && ((req_addr & msk[b]) == (cfg_base[b*AW +: AW] & msk[b]));
  end

  logic           d_hit;
  logic [PBW-1:0] d_pb;

  always_comb begin
    d_hit = 1'b0;
    d_pb  = '0;
    for (int b = NB-1; b >= 0; b--)
      if (match[b]) begin
        d_hit = 1'b1;
        d_pb  = PBW'(b);
      end
  end

  logic [2:0]    d_geom;
  logic          d_quad;
  logic [3:0]    cb, rb, ibw;
  logic [AW-1:0] word;
  logic [RW-1:0] d_row;
  logic [CW-1:0] d_col;
  logic [1:0]    d_ib;

  assign d_geom = cfg_geom[d_pb*3 +: 3];
  assign d_quad = cfg_quad[d_pb];
  assign cb     = col_bits(d_geom);
  assign rb     = row_bits(d_geom);
  assign ibw    = d_quad ? 4'd2 : 4'd1;
  assign word   = (req_addr & ~msk[d_pb]) >> 2;
  assign d_col  = CW'(word & ((AW'(1) << cb) - AW'(1)));
  assign d_ib   = 2'((word >> cb) & (d_quad ? AW'(3) : AW'(1)));
  assign d_row  = RW'((word >> (cb + ibw)) & ((AW'(1) << rb) - AW'(1)));

  logic [NS-1:0]  v;
  logic [PBW-1:0] t_pb  [NS];
  logic [1:0]     t_ib  [NS];
  logic [RW-1:0]  t_row [NS];
  logic [SW-1:0]  age   [NS];

  logic          same_any, free_any, c_any;
  logic [SW-1:0] same_idx, free_idx, lru_idx, c_idx;

  always_comb begin
    same_any = 1'b0; same_idx = '0;
    free_any = 1'b0; free_idx = '0;
    c_any    = 1'b0; c_idx    = '0;
    lru_idx  = '0;
    for (int s = NS-1; s >= 0; s--) begin
      if (v[s] && t_pb[s] == d_pb && t_ib[s] == d_ib) begin
        same_any = 1'b1; same_idx = SW'(s);
      end
      if (v[s] && t_pb[s] == close_pbank && t_ib[s] == close_ibank) begin
        c_any = 1'b1; c_idx = SW'(s);
      end
      if (!v[s]) begin
        free_any = 1'b1; free_idx = SW'(s);
      end
      if (age[s] == SW'(NS-1)) lru_idx = SW'(s);
    end
  end

  logic          row_eq, take;
  logic [SW-1:0] tgt;
  logic [SW:0]   ref_age;

  assign row_eq  = t_row[same_idx] == d_row;
  assign take    = req_valid && d_hit;
  assign tgt     = same_any ? same_idx : (free_any ? free_idx : lru_idx);
  assign ref_age = same_any ? {1'b0, age[same_idx]} :
                   (free_any ? (SW+1)'(NS) : (SW+1)'(NS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_err <= 1'b0;
      rsp_hit <= 1'b0; rsp_miss <= 1'b0; rsp_empty <= 1'b0;
      rsp_pbank <= '0; rsp_row <= '0; rsp_col <= '0; rsp_ibank <= '0;
      rsp_evict <= 1'b0; rsp_evict_pbank <= '0; rsp_evict_ibank <= '0;
      v <= '0;
      for (int s = 0; s < NS; s++) begin
        t_pb[s] <= '0; t_ib[s] <= '0; t_row[s] <= '0; age[s] <= '0;
      end
    end else begin
      rsp_valid       <= req_valid;
      rsp_err         <= req_valid && !d_hit;
      rsp_hit         <= take && same_any && row_eq;
      rsp_miss        <= take && same_any && !row_eq;
      rsp_empty       <= take && !same_any;
      rsp_evict       <= take && !same_any && !free_any;
      rsp_evict_pbank <= t_pb[lru_idx];
      rsp_evict_ibank <= t_ib[lru_idx];
      rsp_pbank       <= d_pb;
      rsp_row         <= d_row;
      rsp_col         <= d_col;
      rsp_ibank       <= d_ib;
      if (take) begin
        for (int s = 0; s < NS; s++)
          if (SW'(s) == tgt) age[s] <= '0;
          else if (v[s] && {1'b0, age[s]} < ref_age) age[s] <= age[s] + 1'b1;
        v[tgt]     <= 1'b1;
        t_pb[tgt]  <= d_pb;
        t_ib[tgt]  <= d_ib;
        t_row[tgt] <= d_row;
      end else if (close_valid && c_any && !req_valid) begin
        v[c_idx] <= 1'b0;
        for (int s = 0; s < NS; s++)
          if (v[s] && age[s] > age[c_idx]) age[s] <= age[s] - 1'b1;
      end
      if (prech_all) v <= '0;
    end
  end

endmodule

module sdram_page_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic prech_all,
  input logic rsp_valid,
  input logic rsp_err,
  input logic rsp_hit,
  input logic rsp_miss,
  input logic rsp_empty,
  input logic rsp_evict
);
  assert_resp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> $countones({rsp_hit, rsp_miss, rsp_empty}) == 1);
  assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && !rsp_hit && !rsp_miss && !rsp_empty && !rsp_evict));
  assert_evict_on_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_evict |-> rsp_empty);
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prech_all ##1 req_valid |=> (rsp_empty || rsp_err));
endmodule

bind sdram_page_tracker sdram_page_tracker_chk u_chk (.*);

// File: tb/tb_sdram_page_tracker.sv
module tb_sdram_page_tracker;
  localparam int NB = 4, AW = 32, RW = 13, CW = 11, PBW = 2;

  logic clk = 0, rst_n = 0;
  logic [NB-1:0] cfg_en;
  logic [NB*AW-1:0] cfg_base;
  logic [NB*3-1:0] cfg_size, cfg_geom;
  logic [NB-1:0] cfg_quad;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic close_valid = 0;
  logic [PBW-1:0] close_pbank = '0;
  logic [1:0] close_ibank = '0;
  logic prech_all = 0;
  logic rsp_valid, rsp_err, rsp_hit, rsp_miss, rsp_empty, rsp_evict;
  logic [PBW-1:0] rsp_pbank, rsp_evict_pbank;
  logic [RW-1:0] rsp_row;
  logic [CW-1:0] rsp_col;
  logic [1:0] rsp_ibank, rsp_evict_ibank;

  always #10 clk = ~clk;

  sdram_page_tracker dut (.*);

  int en_c[NB], size_c[NB], geom_c[NB], quad_c[NB];
  longint base_c[NB];

  typedef struct {
    bit err; bit hit; bit miss; bit empty;
    int pb; int row; int col; int ib;
    bit ev; int evpb; int evib;
    string tag;
  } exp_t;
  exp_t q[$];

  bit mv[4];
  int mpb[4], mib[4], mrow[4];
  longint mstamp[4];
  longint now_t = 0;

  int nchk = 0, nfail = 0;
  bit done = 0;

  function automatic int rbits(int g);
    if (g <= 1) return 11;
    if (g <= 4) return 12;
    return 13;
  endfunction

  function automatic int cbits(int g);
    case (g)
      0, 2: return 8;
      1, 3, 5: return 9;
      4, 6: return 10;
      default: return 11;
    endcase
  endfunction

  function automatic longint bsize(int b);
    return 64'd1 << (22 + ((size_c[b] == 7) ? 6 : size_c[b]));
  endfunction

  function automatic longint mk_addr(int b, int row, int ib, int col);
    longint nib = quad_c[b] ? 4 : 2;
    longint w = ((longint'(row) * nib + ib) << cbits(geom_c[b])) + col;
    return base_c[b] + w * 4;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic apply_cfg();
    for (int b = 0; b < NB; b++) begin
      cfg_en[b] = en_c[b][0];
      cfg_base[b*AW +: AW] = base_c[b][31:0];
      cfg_size[b*3 +: 3] = size_c[b][2:0];
      cfg_geom[b*3 +: 3] = geom_c[b][2:0];
      cfg_quad[b] = quad_c[b][0];
    end
  endtask

  task automatic do_req(longint a, string tag);
    exp_t e;
    bit ok = 0;
    int pb = 0;
    longint word, nib;
    int cb;
    for (int b = NB-1; b >= 0; b--)
      if (en_c[b] != 0 && (a / bsize(b)) == (base_c[b] / bsize(b))) begin
        ok = 1; pb = b;
      end
    e.tag = tag; e.err = !ok; e.hit = 0; e.miss = 0; e.empty = 0; e.ev = 0;
    e.pb = pb; e.evpb = 0; e.evib = 0;
    word = (a % bsize(pb)) / 4;
    cb = cbits(geom_c[pb]);
    nib = quad_c[pb] ? 4 : 2;
    e.col = int'(word % (64'd1 << cb));
    e.ib = int'((word >> cb) % nib);
    e.row = int'(((word >> cb) / nib) % (64'd1 << rbits(geom_c[pb])));
    if (ok) begin
      int slot = -1;
      now_t++;
      for (int s = 0; s < 4; s++)
        if (mv[s] && mpb[s] == e.pb && mib[s] == e.ib) slot = s;
      if (slot >= 0) begin
        if (mrow[slot] == e.row) e.hit = 1; else e.miss = 1;
      end else begin
        e.empty = 1;
        for (int s = 3; s >= 0; s--) if (!mv[s]) slot = s;
        if (slot < 0) begin
          slot = 0;
          for (int s = 1; s < 4; s++) if (mstamp[s] < mstamp[slot]) slot = s;
          e.ev = 1; e.evpb = mpb[slot]; e.evib = mib[slot];
        end
      end
      mv[slot] = 1; mpb[slot] = e.pb; mib[slot] = e.ib; mrow[slot] = e.row;
      mstamp[slot] = now_t;
    end
    req_valid = 1; req_addr = a[31:0];
    q.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_close(int pb, int ib);
    for (int s = 0; s < 4; s++)
      if (mv[s] && mpb[s] == pb && mib[s] == ib) mv[s] = 0;
    close_valid = 1; close_pbank = pb[PBW-1:0]; close_ibank = ib[1:0];
    @(negedge clk);
    close_valid = 0;
  endtask

  task automatic do_prech();
    for (int s = 0; s < 4; s++) mv[s] = 0;
    prech_all = 1;
    @(negedge clk);
    prech_all = 0;
  endtask

  // scoreboard monitor: sampled 5 ns after the active edge
  always begin
    exp_t e;
    @(posedge clk);
    #5;
    if (rst_n && !done) begin
      if (rsp_valid && q.size() == 0) chk(0, "R3", "unexpected rsp_valid", 1, 0);
      else if (!rsp_valid && q.size() != 0) chk(0, "R3", "missing rsp_valid", 0, 1);
      else if (rsp_valid) begin
        e = q.pop_front();
        chk(1, "R3", "response", 1, 1);
        if (e.err) begin
          chk(rsp_err == 1 && !rsp_hit && !rsp_miss && !rsp_empty && !rsp_evict,
              "R2", "decode error flags", {rsp_err, rsp_hit, rsp_miss, rsp_empty, rsp_evict}, 5'b10000);
        end else begin
          chk(rsp_err == 0 && int'(rsp_pbank) == e.pb, "R1", "pbank/err",
              {rsp_err, 2'b0, rsp_pbank}, e.pb);
          chk(int'(rsp_row) == e.row, (e.tag == "R10") ? "R10" : "R4", "row", rsp_row, e.row);
          chk(int'(rsp_col) == e.col, "R4", "col", rsp_col, e.col);
          chk(int'(rsp_ibank) == e.ib, (e.tag == "R10") ? "R10" : "R4", "ibank", rsp_ibank, e.ib);
          chk(rsp_hit == e.hit && rsp_miss == e.miss && rsp_empty == e.empty,
              (e.tag == "R10") ? "R5" : e.tag, "hit/miss/empty",
              {rsp_hit, rsp_miss, rsp_empty}, {e.hit, e.miss, e.empty});
          chk(rsp_evict == e.ev, "R6", "evict", rsp_evict, e.ev);
          if (e.ev && rsp_evict)
            chk(int'(rsp_evict_pbank) == e.evpb && int'(rsp_evict_ibank) == e.evib, "R6",
                "victim pbank/ibank", {rsp_evict_pbank, rsp_evict_ibank}, e.evpb * 4 + e.evib);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    en_c = '{1, 1, 1, 1};
    base_c = '{64'h0000_0000, 64'h0100_0000, 64'h1000_0000, 64'h1000_0000};
    size_c = '{0, 2, 6, 0};
    geom_c = '{0, 2, 7, 1};
    quad_c = '{0, 1, 1, 0};
    apply_cfg();
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "R9", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R9", "rsp_valid after reset", rsp_valid, 0);

    do_req(mk_addr(0, 1, 0, 5), "R9");      // empty table after reset
    do_req(mk_addr(0, 1, 0, 5), "R5");      // hit
    do_req(mk_addr(0, 1, 0, 9), "R5");      // hit, other column
    do_req(mk_addr(0, 2, 0, 3), "R5");      // miss
    do_req(mk_addr(0, 2, 1, 255), "R10");   // 2-bank internal bank 1
    do_req(mk_addr(1, 3, 3, 17), "R10");    // 4-bank internal bank 3
    do_req(mk_addr(2, 7, 2, 2047), "R5");   // table now full
    do_req(mk_addr(0, 1, 0, 0), "R5");      // miss touches b0/i0
    do_req(mk_addr(2, 7, 1, 1), "R6");      // evicts b0/i1
    do_req(mk_addr(0, 2, 1, 4), "R6");      // evicts b1/i3
    do_req(64'h3000_0000, "R2");
    do_req(64'h0040_0000, "R2");            // just past bank 0
    do_req(64'h1000_0000, "R1");            // overlap: bank 2 wins over 3
    do_close(2, 1);
    do_req(mk_addr(2, 7, 1, 8), "R7");      // reopen after close
    do_prech();
    do_req(mk_addr(0, 2, 1, 4), "R8");
    do_req(mk_addr(2, 7, 1, 8), "R8");

    base_c[3] = 64'h4000_0000; size_c[3] = 7; // code 7 acts as 256 MB
    apply_cfg();
    @(negedge clk);
    do_req(64'h4FFF_FFF0, "R1");
    do_req(64'h5000_0000, "R2");

    for (int i = 0; i < 400; i++) begin
      int b, op;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op = int'(lfsr[4:0]);
      b = int'(lfsr[6:5]);
      if (op == 0) do_prech();
      else if (op < 3) do_close(b, int'(lfsr[8:7]) % (quad_c[b] ? 4 : 2));
      else if (op == 3) do_req(64'h6000_0000 + longint'(lfsr[15:0]), "R2");
      else do_req(mk_addr(b, int'(lfsr[10:9]) % 3, int'(lfsr[12:11]) % (quad_c[b] ? 4 : 2),
                          int'(lfsr[23:13]) % (1 << cbits(geom_c[b]))), "R5");
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R3", "pending responses at end", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule